// File: doc/BRIEF.md
# Sixteen-Entry Tag Matcher with Replacement Hint

This block holds sixteen 32-bit tags, each with a 4-bit state field and a valid flag. A lookup presents a 32-bit key. The key is compared against every valid entry at once. One clock later the block returns a 32-bit result word. The 9-bit result sits in bits 11:3 of that word. On a hit it names the matching entry and gives that entry's state. On a miss it names the entry used longest ago, which the caller can treat as the slot to refill.

Software-visible refills go through the full write port, which loads the tag and state of one entry and marks it valid. The state-only port changes just the 4-bit state of one entry. The block keeps a complete recency ordering of all sixteen entries. A lookup hit makes the matched entry the most recent. A full write does the same for the written entry. A miss and a state-only write leave the ordering alone.

Top module: `cam_lru_top`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears all entries to invalid with state 0. It also sets the recency order so that entry 0 is the least recent and entry 15 the most recent. A lookup right after reset therefore reports a miss on entry 0.
- R2: The result word has this layout: bits [11:8] are the state, bit [7] is the hit flag (1 = hit), and bits [6:3] are the entry number. All other bits are 0.
- R3: A lookup presented at one clock edge shows its result at the next edge, with res_valid high for that cycle. On a hit, the hit flag is 1, the entry number is the matching entry, and the state is that entry's stored state.
- R4: On a miss, the hit flag is 0, the state bits are 0000, and the entry number is the least recently used entry at the time of the lookup.
- R5: An invalid entry never matches, even when its stored tag equals the key.
- R6: When several valid entries match the key, the lowest-numbered one is reported.
- R7: A lookup hit and a full write each make their entry the most recently used. A lookup miss leaves the recency order unchanged.
- R8: A state-only write changes only that entry's state. It does not change the entry's tag, its valid flag or the recency order.
- R9: When a lookup and writes fall in the same cycle, the lookup sees the contents from before those writes. The recency update then applies the lookup hit first and the full write second, so the written entry ends as the most recent.
- R10: In a cycle with no lookup result, res_valid is low and res_word is zero.
- R11: When a full write and a state-only write target the same entry in the same cycle, the state from the full write is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_key | input | 32 | Key to search for |
| wr_en | input | 1 | Full entry write enable |
| wr_idx | input | 4 | Entry written by the full write |
| wr_tag | input | 32 | Tag to store |
| wr_state | input | 4 | State stored with the tag |
| st_en | input | 1 | State-only write enable |
| st_idx | input | 4 | Entry whose state is changed |
| st_val | input | 4 | New state value |
| res_valid | output | 1 | Result present, one cycle after the request |
| res_word | output | 32 | Packed lookup result |

## Verification
A lookup can share a cycle with a full write or a state-only write, aimed at the entry it hits or at another entry. The bench drives these combinations in a single cycle. It judges the returned word against the contents from before the write. It then reads the recency order back through later misses. This confirms that the hit was applied before the write. A further cycle drives both write ports at one entry to check which state is stored.

// File: rtl/cam_pkg.sv
// Package: shared defaults and result layout for the tag matcher.
// Assumes: the result field starts at a fixed bit of the destination word.
package cam_pkg;
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_TAG_W   = 32;
    localparam int DEF_STATE_W = 4;
    localparam int DEF_WORD_W  = 32;
    localparam int RES_LSB     = 3;
endpackage

// File: rtl/cam_store.sv
// Module: cam_store
// Holds the tag, state and valid flag of every entry.
// Assumes: a full write has priority over a state-only write to the same entry.
module cam_store #(
    parameter int N   = 16,
    parameter int TW  = 32,
    parameter int SW  = 4,
    parameter int IW  = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [TW-1:0]   wr_tag,
    input  logic [SW-1:0]   wr_state,
    input  logic            st_en,
    input  logic [IW-1:0]   st_idx,
    input  logic [SW-1:0]   st_val,
    output logic [N*TW-1:0] tag_flat,
    output logic [N*SW-1:0] state_flat,
    output logic [N-1:0]    valid_vec
);
    logic [TW-1:0] tag_q   [N];
    logic [SW-1:0] state_q [N];
    logic [N-1:0]  valid_q;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_entry
            // Update one entry's tag, state and valid flag from the write ports.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_q[g]   <= '0;
                    state_q[g] <= '0;
                    valid_q[g] <= 1'b0;
                end else if (wr_en && (wr_idx == IW'(g))) begin
                    tag_q[g]   <= wr_tag;
                    state_q[g] <= wr_state;
                    valid_q[g] <= 1'b1;
                end else if (st_en && (st_idx == IW'(g))) begin
                    state_q[g] <= st_val;
                end
            end

            // Flatten the entry onto the output buses.
            always_comb begin
                tag_flat[g*TW +: TW]   = tag_q[g];
                state_flat[g*SW +: SW] = state_q[g];
            end
        end
    endgenerate

    assign valid_vec = valid_q;
endmodule

// File: rtl/cam_match.sv
// Module: cam_match
// Compares a key against all entries in parallel and picks the lowest match.
// Assumes: invalid entries are masked out before the priority pick.
module cam_match #(
    parameter int N  = 16,
    parameter int TW = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [TW-1:0]   key,
    input  logic [N*TW-1:0] tag_flat,
    input  logic [N-1:0]    valid_vec,
    output logic            hit,
    output logic [IW-1:0]   hit_idx
);
    logic [N-1:0] match_vec;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_cmp
            // Per-entry equality comparison, qualified by the valid flag.
            assign match_vec[g] = valid_vec[g] && (tag_flat[g*TW +: TW] == key);
        end
    endgenerate

    // Lowest-numbered matching entry wins.
    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match_vec[i]) hit_idx = IW'(i);
        end
    end

    assign hit = |match_vec;
endmodule

// File: rtl/cam_lru.sv
// Module: cam_lru
// Keeps a full recency order: slot 0 is least recent, slot N-1 most recent.
// Assumes: up to two touches per cycle, applied in the order a then b.
module cam_lru #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch_a,
    input  logic [IW-1:0]   touch_a_idx,
    input  logic            touch_b,
    input  logic [IW-1:0]   touch_b_idx,
    output logic [IW-1:0]   lru_idx,
    output logic [N*IW-1:0] order_flat
);
    logic [N*IW-1:0] order_q;
    logic [N*IW-1:0] after_a;
    logic [N*IW-1:0] after_b;

    // Move entry e to the most recent slot and close the gap it leaves.
    function automatic logic [N*IW-1:0] touch(input logic [N*IW-1:0] ord,
                                              input logic [IW-1:0]   e);
        logic [N*IW-1:0] r;
        logic            seen;
        r    = ord;
        seen = 1'b0;
        for (int i = 0; i < N - 1; i++) begin
            if (ord[i*IW +: IW] == e) seen = 1'b1;
            if (seen) r[i*IW +: IW] = ord[(i+1)*IW +: IW];
        end
        r[(N-1)*IW +: IW] = e;
        return r;
    endfunction

    // Apply the lookup touch, then the write touch.
    always_comb begin
        after_a = touch_a ? touch(order_q, touch_a_idx) : order_q;
        after_b = touch_b ? touch(after_a, touch_b_idx) : after_a;
    end

    // Hold the order; reset to ascending entry numbers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) order_q[i*IW +: IW] <= IW'(i);
        end else begin
            order_q <= after_b;
        end
    end

    assign lru_idx    = order_q[IW-1:0];
    assign order_flat = order_q;
endmodule

// File: rtl/cam_lru_top.sv
// Module: cam_lru_top
// Tag matcher with a recency-based replacement hint and a registered result.
// Assumes: a lookup sees contents from before any write in the same cycle.
module cam_lru_top
    import cam_pkg::*;
#(
    parameter int N      = DEF_ENTRIES,
    parameter int TW     = DEF_TAG_W,
    parameter int SW     = DEF_STATE_W,
    parameter int WORD_W = DEF_WORD_W,
    parameter int IW     = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [TW-1:0]     lkp_key,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [TW-1:0]     wr_tag,
    input  logic [SW-1:0]     wr_state,
    input  logic              st_en,
    input  logic [IW-1:0]     st_idx,
    input  logic [SW-1:0]     st_val,
    output logic              res_valid,
    output logic [WORD_W-1:0] res_word
);
    localparam int RES_W = SW + 1 + IW;

    logic [N*TW-1:0] tag_flat;
    logic [N*SW-1:0] state_flat;
    logic [N-1:0]    valid_vec;
    logic            hit_any;
    logic [IW-1:0]   hit_idx;
    logic [IW-1:0]   lru_idx;
    logic [N*IW-1:0] lru_order;
    logic [RES_W-1:0] res_field;

    cam_store #(.N(N), .TW(TW), .SW(SW), .IW(IW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_tag     (wr_tag),
        .wr_state   (wr_state),
        .st_en      (st_en),
        .st_idx     (st_idx),
        .st_val     (st_val),
        .tag_flat   (tag_flat),
        .state_flat (state_flat),
        .valid_vec  (valid_vec)
    );

    cam_match #(.N(N), .TW(TW), .IW(IW)) u_match (
        .key       (lkp_key),
        .tag_flat  (tag_flat),
        .valid_vec (valid_vec),
        .hit       (hit_any),
        .hit_idx   (hit_idx)
    );

    cam_lru #(.N(N), .IW(IW)) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_a     (lkp_valid && hit_any),
        .touch_a_idx (hit_idx),
        .touch_b     (wr_en),
        .touch_b_idx (wr_idx),
        .lru_idx     (lru_idx),
        .order_flat  (lru_order)
    );

    // Assemble state, hit flag and entry number for the current lookup.
    always_comb begin
        if (hit_any) res_field = {state_flat[hit_idx*SW +: SW], 1'b1, hit_idx};
        else         res_field = {{SW{1'b0}}, 1'b0, lru_idx};
    end

    // Register the result one cycle after the request; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_word  <= '0;
        end else begin
            res_valid <= lkp_valid;
            res_word  <= lkp_valid ? (WORD_W'(res_field) << RES_LSB) : '0;
        end
    end
endmodule

// File: rtl/cam_lru_chk.sv
// Module: cam_lru_chk
// Property checker for cam_lru_top, attached with bind.
// Assumes: the recency order bus and the match flag are visible in the top.
module cam_lru_chk
    import cam_pkg::*;
#(
    parameter int N      = 16,
    parameter int SW     = 4,
    parameter int WORD_W = 32,
    parameter int IW     = $clog2(N)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lkp_valid,
    input logic              wr_en,
    input logic              st_en,
    input logic              hit_any,
    input logic [N*IW-1:0]   lru_order,
    input logic              res_valid,
    input logic [WORD_W-1:0] res_word
);
    localparam int HIT_BIT = RES_LSB + IW;
    localparam int TOP_BIT = RES_LSB + IW + 1 + SW;

    assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (res_word == '0));

    assert_spare_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_word >> TOP_BIT) == '0) && (res_word[RES_LSB-1:0] == '0));

    assert_miss_state_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_word[HIT_BIT]) |-> (res_word[TOP_BIT-1:HIT_BIT+1] == '0));

    assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> res_valid);

    assert_no_spurious_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !res_valid);

    assert_miss_keeps_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && !hit_any && !wr_en) |=> $stable(lru_order));

    assert_state_write_keeps_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && !wr_en && !(lkp_valid && hit_any)) |=> $stable(lru_order));
endmodule

bind cam_lru_top cam_lru_chk #(.N(N), .SW(SW), .WORD_W(WORD_W), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .wr_en     (wr_en),
    .st_en     (st_en),
    .hit_any   (hit_any),
    .lru_order (lru_order),
    .res_valid (res_valid),
    .res_word  (res_word)
);

// File: tb/tb_cam_lru_top.sv
module tb_cam_lru_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_key = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_tag = '0;
    logic [3:0]  wr_state = '0;
    logic        st_en = 1'b0;
    logic [3:0]  st_idx = '0;
    logic [3:0]  st_val = '0;
    logic        res_valid;
    logic [31:0] res_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model of the requirements.
    logic [31:0] m_tag   [16];
    logic [3:0]  m_state [16];
    bit          m_valid [16];
    int          m_order [16];

    always #2.5 clk = ~clk;

    cam_lru_top dut (
        .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_key(lkp_key),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_state(wr_state),
        .st_en(st_en), .st_idx(st_idx), .st_val(st_val),
        .res_valid(res_valid), .res_word(res_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void m_touch(input int e);
        int p = 0;
        for (int i = 0; i < 16; i++) if (m_order[i] == e) p = i;
        for (int i = p; i < 15; i++) m_order[i] = m_order[i+1];
        m_order[15] = e;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 16; i++) begin
            m_tag[i] = '0; m_state[i] = '0; m_valid[i] = 0; m_order[i] = i;
        end
    endfunction

    // One cycle of stimulus; called at a falling edge, returns at the next one.
    task automatic cycle(input bit lv, input logic [31:0] key,
                         input bit we, input int wi, input logic [31:0] wt, input logic [3:0] ws,
                         input bit se, input int si, input logic [3:0] sv, input string req);
        logic [31:0] exp;
        int hi = -1;
        for (int i = 15; i >= 0; i--) if (m_valid[i] && m_tag[i] == key) hi = i;
        if (hi >= 0) exp = (32'(m_state[hi]) << 8) | 32'h80 | (32'(hi) << 3);
        else         exp = 32'(m_order[0]) << 3;
        lkp_valid = lv; lkp_key = key;
        wr_en = we; wr_idx = 4'(wi); wr_tag = wt; wr_state = ws;
        st_en = se; st_idx = 4'(si); st_val = sv;
        if (lv && hi >= 0) m_touch(hi);
        if (se) m_state[si] = sv;
        if (we) begin m_tag[wi] = wt; m_state[wi] = ws; m_valid[wi] = 1; m_touch(wi); end
        @(negedge clk);
        lkp_valid = 0; wr_en = 0; st_en = 0;
        if (lv) begin
            check({req, " valid"}, 32'(res_valid), 32'd1);
            check({req, " word"}, res_word, exp);
        end else begin
            check({req, " idle"}, {31'd0, res_valid} | res_word, 32'd0);
        end
    endtask

    task automatic lookup(input logic [31:0] key, input string req);
        cycle(1, key, 0, 0, '0, '0, 0, 0, '0, req);
    endtask

    task automatic write(input int i, input logic [31:0] t, input logic [3:0] s);
        cycle(0, '0, 1, i, t, s, 0, 0, '0, "R10 write");
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_reset();
    endtask

    // R1, R5, R10: reset state, empty table misses on entry 0 even with key 0.
    task automatic t_reset();
        do_reset();
        check("R10 reset idle", {31'd0, res_valid} | res_word, 32'd0);
        lookup(32'h0, "R5 invalid tag0");
        check("R1 miss entry0", res_word, 32'h0);
    endtask

    // R2, R3: a single hit with known packing.
    task automatic t_hit();
        write(5, 32'hCAFE_0005, 4'h9);
        lookup(32'hCAFE_0005, "R3 hit");
        check("R2 packing", res_word, 32'h0000_09A8);
    endtask

    // R4, R7: fill all entries and observe recency via misses.
    task automatic t_order();
        for (int i = 15; i >= 0; i--) write(i, 32'h1000_0000 + 32'(i), 4'(i));
        lookup(32'hDEAD_BEEF, "R4 miss after fill");
        lookup(32'hDEAD_BEEF, "R7 miss keeps order");
        lookup(32'h1000_000F, "R7 hit lru");
        lookup(32'h1000_000E, "R7 hit next");
        lookup(32'hDEAD_BEEF, "R7 miss after hits");
        for (int i = 0; i < 14; i++) lookup(32'h1000_0000 + 32'(i), "R7 touch");
        lookup(32'hDEAD_BEEF, "R4 lru after touches");
    endtask

    // R6: duplicate tags report the lowest entry.
    task automatic t_dup();
        write(9, 32'h5555_AAAA, 4'h2);
        write(3, 32'h5555_AAAA, 4'h7);
        lookup(32'h5555_AAAA, "R6 lowest match");
        lookup(32'hDEAD_BEEF, "R6 miss");
    endtask

    // R8: state-only write changes state only.
    task automatic t_state();
        cycle(0, '0, 0, 0, '0, '0, 1, 12, 4'hC, "R8 state write");
        lookup(32'h1000_000C, "R8 new state");
        lookup(32'hDEAD_BEEF, "R8 order kept");
        cycle(0, '0, 0, 0, '0, '0, 1, 1, 4'h6, "R8 state write");
        lookup(32'hDEAD_BEEF, "R8 order kept again");
    endtask

    // R9, R11: same-cycle lookup and writes.
    task automatic t_same_cycle();
        cycle(1, 32'h1000_0004, 1, 4, 32'h7777_0004, 4'hB, 0, 0, '0, "R9 lookup old contents");
        lookup(32'h1000_0004, "R9 old tag gone");
        lookup(32'h7777_0004, "R9 new tag");
        cycle(1, 32'h1000_0007, 1, 8, 32'h7777_0008, 4'h1, 1, 7, 4'hE, "R9 hit then write");
        lookup(32'h1000_0007, "R9 state after");
        lookup(32'hDEAD_BEEF, "R9 order");
        cycle(0, '0, 1, 10, 32'h7777_000A, 4'h3, 1, 10, 4'hF, "R11 both writes");
        lookup(32'h7777_000A, "R11 full write wins");
    endtask

    // R1: reset mid-run restores empty table and order.
    task automatic t_rereset();
        do_reset();
        lookup(32'h7777_000A, "R1 cleared");
        check("R1 entry0 after reset", res_word, 32'h0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_hit();
        t_order();
        t_dup();
        t_state();
        t_same_cycle();
        t_rereset();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule